// File: doc/BRIEF.md
# Context-Tagged Translation Lookaside Buffer

This block is a fully associative translation buffer for a 32-bit virtual address space with 4 KB pages. Each entry carries a three-bit level code that sets how many upper address bits take part in the tag compare. One entry can therefore map a 16 MB region, a 256 KB segment or a single 4 KB page. The top bit of that code also marks the entry valid. Each entry is also tagged with a 6-bit context number. That number is compared with a current-context register that software loads, unless the entry is flagged as a supervisor mapping, which matches in every context.

A lookup is combinational. The caller presents a virtual address, an access code and a privilege flag, and in the same cycle gets back hit, the translated physical address, a protection fault, an I/O indication and the state of the entry's modified bit. When a permitted write hits, the modified bit of the matched entry is set at the next clock edge. New entries are written through a fill port in round-robin order, and a flush input invalidates every entry in one cycle. Table walking is left to the surrounding logic.

Top module: `vtlb_top`

## Requirements
- R1: After reset every entry is invalid, the current context is 0 and the fill slot is entry 0, so every lookup misses.
- R2: An entry matches only when its level code has bit 2 set. Code 100 compares VA[31:24] with tag bits [19:12], code 110 compares VA[31:18] with tag bits [19:6], code 111 compares VA[31:12] with the whole 20-bit tag, and code 101 behaves as 100. A code with bit 2 clear never matches.
- R3: An entry whose supervisor flag is 0 matches only when its context equals the current context. An entry whose supervisor flag is 1 matches in any context.
- R4: On a hit the physical address is {PPN[19:12], VA[23:0]} for span 100, {PPN[19:6], VA[17:0]} for span 110 and {PPN, VA[11:0]} for span 111.
- R5: On a miss the hit, fault, I/O, modified and modified-update outputs are 0 and the physical address is 0.
- R6: The permission bit used is perm[priv*3 + acc], with perm[0..2] = user read/write/execute, perm[3..5] = supervisor read/write/execute, and acc 0 = read, 1 = write, 2 = execute. Access code 3 is never permitted. A hit whose permission bit is clear raises the fault output.
- R7: A requested (lk_req_i=1) write that hits without fault sets the matched entry's modified bit at the next edge. lk_mod_set_o is high in that cycle if the bit was still 0, and lk_mod_o shows the stored bit of the matched entry. A faulting access leaves the bit unchanged.
- R8: Each fill writes the entry at the fill slot, clears its modified bit and advances the slot by one, wrapping from the last entry to entry 0.
- R9: A flush clears every entry's valid bit in one cycle. A fill in the same cycle is dropped and the fill slot does not move.
- R10: When several entries match, the lowest-numbered one supplies all outputs.
- R11: lk_io_o is high exactly when a hit entry's active-low I/O flag is 0.
- R12: A context write takes effect for lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| ctx_we_i | input | 1 | Load the current-context register |
| ctx_wdata_i | input | 6 | New current context |
| fill_we_i | input | 1 | Write one entry at the fill slot |
| fill_vtag_i | input | 20 | Virtual tag, VA[31:12] |
| fill_ctx_i | input | 6 | Context of the new entry |
| fill_level_i | input | 3 | Level code of the new entry |
| fill_sup_i | input | 1 | Match in every context |
| fill_io_n_i | input | 1 | Active-low I/O flag |
| fill_perm_i | input | 6 | Permission bits (see R6) |
| fill_ppn_i | input | 20 | Physical page number |
| lk_req_i | input | 1 | Lookup is a real access (enables modified update) |
| lk_va_i | input | 32 | Virtual address |
| lk_acc_i | input | 2 | Access code (see R6) |
| lk_priv_i | input | 1 | 1 = supervisor access |
| lk_hit_o | output | 1 | An entry matched |
| lk_pa_o | output | 32 | Physical address |
| lk_fault_o | output | 1 | Protection fault |
| lk_io_o | output | 1 | Matched entry is an I/O mapping |
| lk_mod_o | output | 1 | Modified bit of the matched entry |
| lk_mod_set_o | output | 1 | This access sets the modified bit |

## Verification
A corrupted level code or tag shows up in the same cycle at the next lookup of an address under that entry, as a spurious hit or miss, or as a physical address that splices the wrong number of untranslated bits. A stuck modified bit shows at the second write to the same entry, where lk_mod_set_o and lk_mod_o disagree with what the first write should have left. A fill slot that drifts is exposed only after the buffer wraps, when an old mapping survives or a fresh one vanishes. For that reason the bench models every entry and compares all outputs on every cycle, long enough to wrap several times.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;
   localparam int VTAG_W   = 20;
   localparam int PPN_W    = 20;
   localparam int CTX_W    = 6;
   localparam int LVL_W    = 3;
   localparam int PERM_W   = 6;
   localparam int SEG_LSB  = 6;    // tag bit where the 110 span ends
   localparam int REG_LSB  = 12;   // tag bit where the 100 span ends

   typedef enum logic [1:0] {
      ACC_RD  = 2'd0,
      ACC_WR  = 2'd1,
      ACC_EX  = 2'd2,
      ACC_RSV = 2'd3
   } acc_e;
endpackage

// File: rtl/vtlb_slot.sv
module vtlb_slot
   import vtlb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              wr_i,
   input  logic [VTAG_W-1:0] wr_vtag_i,
   input  logic [CTX_W-1:0]  wr_ctx_i,
   input  logic [LVL_W-1:0]  wr_lvl_i,
   input  logic              wr_sup_i,
   input  logic              wr_io_n_i,
   input  logic [PERM_W-1:0] wr_perm_i,
   input  logic [PPN_W-1:0]  wr_ppn_i,
   input  logic [VTAG_W-1:0] va_page_i,
   input  logic [CTX_W-1:0]  cur_ctx_i,
   input  logic              set_mod_i,
   output logic              match_o,
   output logic [PPN_W-1:0]  ppn_o,
   output logic [LVL_W-1:0]  lvl_o,
   output logic [PERM_W-1:0] perm_o,
   output logic              io_n_o,
   output logic              mod_o
);
   logic [VTAG_W-1:0] vtag_q;
   logic [CTX_W-1:0]  ctx_q;
   logic [LVL_W-1:0]  lvl_q;
   logic              sup_q, io_n_q, mod_q;
   logic [PERM_W-1:0] perm_q;
   logic [PPN_W-1:0]  ppn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vtag_q <= '0;
         ctx_q  <= '0;
         lvl_q  <= '0;
         sup_q  <= 1'b0;
         io_n_q <= 1'b1;
         perm_q <= '0;
         ppn_q  <= '0;
      end else if (clr_i) begin
         lvl_q  <= '0;
      end else if (wr_i) begin
         vtag_q <= wr_vtag_i;
         ctx_q  <= wr_ctx_i;
         lvl_q  <= wr_lvl_i;
         sup_q  <= wr_sup_i;
         io_n_q <= wr_io_n_i;
         perm_q <= wr_perm_i;
         ppn_q  <= wr_ppn_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         mod_q <= 1'b0;
      else if (wr_i)      mod_q <= 1'b0;
      else if (set_mod_i) mod_q <= 1'b1;
   end

   logic use_seg, use_page, hit_reg, hit_seg, hit_page, ctx_ok;
   always_comb begin
      use_seg  = lvl_q[1];
      use_page = lvl_q[1] & lvl_q[0];
      hit_reg  = va_page_i[VTAG_W-1:REG_LSB] == vtag_q[VTAG_W-1:REG_LSB];
      hit_seg  = va_page_i[REG_LSB-1:SEG_LSB] == vtag_q[REG_LSB-1:SEG_LSB];
      hit_page = va_page_i[SEG_LSB-1:0] == vtag_q[SEG_LSB-1:0];
      ctx_ok   = sup_q | (ctx_q == cur_ctx_i);
      match_o  = lvl_q[LVL_W-1] & ctx_ok & hit_reg &
                 (~use_seg | hit_seg) & (~use_page | hit_page);
   end

   assign ppn_o  = ppn_q;
   assign lvl_o  = lvl_q;
   assign perm_o = perm_q;
   assign io_n_o = io_n_q;
   assign mod_o  = mod_q;

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_i) |-> !lvl_q[LVL_W-1]);
   assert_mod_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_q && !$past(mod_q)) |-> $past(set_mod_i));
endmodule

// File: rtl/vtlb_pick.sv
module vtlb_pick #(
   parameter int N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_o,
   output logic         any_o
);
   logic seen;
   always_comb begin
      seen    = 1'b0;
      grant_o = '0;
      for (int i = 0; i < N; i++) begin
         grant_o[i] = req_i[i] & ~seen;
         seen       = seen | req_i[i];
      end
      any_o = seen;
   end

   assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));
   assert_grant_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[0] |-> grant_o[0]));
endmodule

// File: rtl/vtlb_xlate.sv
module vtlb_xlate
   import vtlb_pkg::*;
(
   input  logic              hit_i,
   input  logic [PPN_W-1:0]  ppn_i,
   input  logic [LVL_W-1:0]  lvl_i,
   input  logic [PERM_W-1:0] perm_i,
   input  logic [23:0]       va_low_i,
   input  logic              priv_i,
   input  logic [1:0]        acc_i,
   output logic [31:0]       pa_o,
   output logic              fault_o
);
   logic       allowed;
   logic [2:0] bit_sel;

   always_comb begin
      bit_sel = (priv_i ? 3'd3 : 3'd0) + {1'b0, acc_i};
      if (acc_e'(acc_i) == ACC_RSV) allowed = 1'b0;
      else                          allowed = perm_i[bit_sel];
      fault_o = hit_i & ~allowed;

      if (!hit_i)
         pa_o = '0;
      else if (lvl_i[1] & lvl_i[0])
         pa_o = {ppn_i, va_low_i[11:0]};
      else if (lvl_i[1])
         pa_o = {ppn_i[PPN_W-1:SEG_LSB], va_low_i[17:0]};
      else
         pa_o = {ppn_i[PPN_W-1:REG_LSB], va_low_i};
   end
endmodule

// File: rtl/vtlb_top.sv
module vtlb_top
   import vtlb_pkg::*;
#(
   parameter int ENTRIES = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        flush_i,
   input  logic        ctx_we_i,
   input  logic [5:0]  ctx_wdata_i,
   input  logic        fill_we_i,
   input  logic [19:0] fill_vtag_i,
   input  logic [5:0]  fill_ctx_i,
   input  logic [2:0]  fill_level_i,
   input  logic        fill_sup_i,
   input  logic        fill_io_n_i,
   input  logic [5:0]  fill_perm_i,
   input  logic [19:0] fill_ppn_i,
   input  logic        lk_req_i,
   input  logic [31:0] lk_va_i,
   input  logic [1:0]  lk_acc_i,
   input  logic        lk_priv_i,
   output logic        lk_hit_o,
   output logic [31:0] lk_pa_o,
   output logic        lk_fault_o,
   output logic        lk_io_o,
   output logic        lk_mod_o,
   output logic        lk_mod_set_o
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("vtlb_top: ENTRIES must be at least 2");
   end
   if (ENTRIES > 64) begin : g_big_entries
      $error("vtlb_top: ENTRIES above 64 makes the match tree too deep");
   end

   logic [CTX_W-1:0] ctx_q;
   logic [IDX_W-1:0] ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n)        ctx_q <= '0;
      else if (ctx_we_i) ctx_q <= ctx_wdata_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (fill_we_i && !flush_i)
         ptr_q <= (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
   end

   logic [ENTRIES-1:0] match, grant, set_mod;
   logic [PPN_W-1:0]   s_ppn  [ENTRIES];
   logic [LVL_W-1:0]   s_lvl  [ENTRIES];
   logic [PERM_W-1:0]  s_perm [ENTRIES];
   logic [ENTRIES-1:0] s_io_n, s_mod;
   logic               any_hit, fault, wr_ok;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
      vtlb_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr_i     (flush_i),
         .wr_i      (fill_we_i && !flush_i && (ptr_q == IDX_W'(i))),
         .wr_vtag_i (fill_vtag_i),
         .wr_ctx_i  (fill_ctx_i),
         .wr_lvl_i  (fill_level_i),
         .wr_sup_i  (fill_sup_i),
         .wr_io_n_i (fill_io_n_i),
         .wr_perm_i (fill_perm_i),
         .wr_ppn_i  (fill_ppn_i),
         .va_page_i (lk_va_i[31:12]),
         .cur_ctx_i (ctx_q),
         .set_mod_i (set_mod[i]),
         .match_o   (match[i]),
         .ppn_o     (s_ppn[i]),
         .lvl_o     (s_lvl[i]),
         .perm_o    (s_perm[i]),
         .io_n_o    (s_io_n[i]),
         .mod_o     (s_mod[i])
      );
      assign set_mod[i] = wr_ok & grant[i];
   end

   vtlb_pick #(.N(ENTRIES)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (match),
      .grant_o (grant),
      .any_o   (any_hit)
   );

   logic [PPN_W-1:0]  sel_ppn;
   logic [LVL_W-1:0]  sel_lvl;
   logic [PERM_W-1:0] sel_perm;
   logic              sel_io, sel_mod;

   always_comb begin
      sel_ppn  = '0;
      sel_lvl  = '0;
      sel_perm = '0;
      sel_io   = 1'b0;
      sel_mod  = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (grant[i]) begin
            sel_ppn  = sel_ppn  | s_ppn[i];
            sel_lvl  = sel_lvl  | s_lvl[i];
            sel_perm = sel_perm | s_perm[i];
            sel_io   = sel_io   | ~s_io_n[i];
            sel_mod  = sel_mod  | s_mod[i];
         end
      end
   end

   vtlb_xlate u_xlate (
      .hit_i    (any_hit),
      .ppn_i    (sel_ppn),
      .lvl_i    (sel_lvl),
      .perm_i   (sel_perm),
      .va_low_i (lk_va_i[23:0]),
      .priv_i   (lk_priv_i),
      .acc_i    (lk_acc_i),
      .pa_o     (lk_pa_o),
      .fault_o  (fault)
   );

   assign wr_ok        = lk_req_i & any_hit & ~fault & (acc_e'(lk_acc_i) == ACC_WR);
   assign lk_hit_o     = any_hit;
   assign lk_fault_o   = fault;
   assign lk_io_o      = sel_io;
   assign lk_mod_o     = sel_mod;
   assign lk_mod_set_o = wr_ok & ~sel_mod;

   assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit_o |-> (lk_pa_o == '0 && !lk_fault_o && !lk_io_o && !lk_mod_set_o));
   assert_fault_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_fault_o |-> lk_hit_o);
   assert_modset_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lk_mod_set_o |-> (lk_hit_o && !lk_fault_o && lk_req_i));
   assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!fill_we_i || flush_i) |-> $stable(ptr_q));
   assert_ctx_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctx_we_i) |-> (ctx_q == $past(ctx_wdata_i)));
endmodule

// File: tb/sim_vtlb_top.sv
`timescale 1ns/1ps
module sim_vtlb_top;
   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 0, ctx_we_i = 0, fill_we_i = 0;
   logic [5:0]  ctx_wdata_i = 0, fill_ctx_i = 0, fill_perm_i = 0;
   logic [19:0] fill_vtag_i = 0, fill_ppn_i = 0;
   logic [2:0]  fill_level_i = 0;
   logic        fill_sup_i = 0, fill_io_n_i = 1;
   logic        lk_req_i = 0, lk_priv_i = 0;
   logic [31:0] lk_va_i = 0;
   logic [1:0]  lk_acc_i = 0;
   logic        lk_hit_o, lk_fault_o, lk_io_o, lk_mod_o, lk_mod_set_o;
   logic [31:0] lk_pa_o;

   always #2.5 clk = ~clk;

   vtlb_top #(.ENTRIES(N)) u0 (.*);

   // reference model
   logic [19:0] m_vtag [N];
   logic [5:0]  m_ctxt [N];
   logic [2:0]  m_lvl  [N];
   logic        m_sup  [N];
   logic        m_io_n [N];
   logic [5:0]  m_perm [N];
   logic [19:0] m_ppn  [N];
   logic        m_mod  [N];
   logic [5:0]  m_ctx;
   int          m_ptr;

   int checks = 0, fails = 0;
   logic        e_hit, e_fault, e_io, e_mod, e_mset;
   logic [31:0] e_pa;
   int          e_idx;

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin
         m_vtag[i] = 0; m_ctxt[i] = 0; m_lvl[i] = 0; m_sup[i] = 0;
         m_io_n[i] = 1; m_perm[i] = 0; m_ppn[i] = 0; m_mod[i] = 0;
      end
      m_ctx = 0;
      m_ptr = 0;
   endtask

   task automatic predict();
      bit m;
      int bi;
      e_hit = 0; e_fault = 0; e_io = 0; e_mod = 0; e_mset = 0; e_pa = 0; e_idx = -1;
      for (int i = 0; i < N; i++) begin
         m = m_lvl[i][2];
         if (lk_va_i[31:24] != m_vtag[i][19:12]) m = 0;
         if (m_lvl[i][1] && lk_va_i[23:18] != m_vtag[i][11:6]) m = 0;
         if (m_lvl[i][1] && m_lvl[i][0] && lk_va_i[17:12] != m_vtag[i][5:0]) m = 0;
         if (!m_sup[i] && m_ctxt[i] != m_ctx) m = 0;
         if (m && e_idx < 0) e_idx = i;
      end
      if (e_idx >= 0) begin
         e_hit = 1;
         bi = (lk_priv_i ? 3 : 0) + int'(lk_acc_i);
         e_fault = (lk_acc_i == 2'd3) ? 1'b1 : !m_perm[e_idx][bi];
         e_io  = !m_io_n[e_idx];
         e_mod = m_mod[e_idx];
         case (m_lvl[e_idx][1:0])
            2'b11:   e_pa = {m_ppn[e_idx], lk_va_i[11:0]};
            2'b10:   e_pa = {m_ppn[e_idx][19:6], lk_va_i[17:0]};
            default: e_pa = {m_ppn[e_idx][19:12], lk_va_i[23:0]};
         endcase
         e_mset = lk_req_i && lk_acc_i == 2'd1 && !e_fault && !e_mod;
      end
   endtask

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // one clock: check outputs mid-cycle, then advance the model at the edge
   task automatic cyc(string tag);
      #1;
      predict();
      chk(tag, "hit",     32'(lk_hit_o),     32'(e_hit));
      chk(tag, "pa",      lk_pa_o,           e_pa);
      chk(tag, "fault",   32'(lk_fault_o),   32'(e_fault));
      chk(tag, "io",      32'(lk_io_o),      32'(e_io));
      chk(tag, "mod",     32'(lk_mod_o),     32'(e_mod));
      chk(tag, "mod_set", 32'(lk_mod_set_o), 32'(e_mset));
      @(posedge clk);
      if (e_hit && lk_req_i && lk_acc_i == 2'd1 && !e_fault) m_mod[e_idx] = 1;
      if (flush_i) begin
         for (int i = 0; i < N; i++) m_lvl[i] = 0;
      end else if (fill_we_i) begin
         m_vtag[m_ptr] = fill_vtag_i; m_ctxt[m_ptr] = fill_ctx_i;
         m_lvl[m_ptr] = fill_level_i; m_sup[m_ptr] = fill_sup_i;
         m_io_n[m_ptr] = fill_io_n_i; m_perm[m_ptr] = fill_perm_i;
         m_ppn[m_ptr] = fill_ppn_i; m_mod[m_ptr] = 0;
         m_ptr = (m_ptr + 1) % N;
      end
      if (ctx_we_i) m_ctx = ctx_wdata_i;
      @(negedge clk);
   endtask

   task automatic fill(logic [19:0] vt, logic [5:0] cx, logic [2:0] lv, logic sp,
                       logic ion, logic [5:0] pm, logic [19:0] pp, string tag);
      fill_we_i = 1; fill_vtag_i = vt; fill_ctx_i = cx; fill_level_i = lv;
      fill_sup_i = sp; fill_io_n_i = ion; fill_perm_i = pm; fill_ppn_i = pp;
      cyc(tag);
      fill_we_i = 0;
   endtask

   task automatic look(logic [31:0] va, logic [1:0] acc, logic pv, logic rq, string tag);
      lk_va_i = va; lk_acc_i = acc; lk_priv_i = pv; lk_req_i = rq;
      cyc(tag);
      lk_req_i = 0;
   endtask

   task automatic finish_run();
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R1: reset state, everything misses
      look(32'h0000_0000, 2'd0, 0, 0, "R1");
      look(32'h1234_5ABC, 2'd0, 1, 1, "R1");
      // R12: context register load
      ctx_we_i = 1; ctx_wdata_i = 6'd5; cyc("R12"); ctx_we_i = 0;
      // R8: fills go to entries 0.. in order
      fill(20'h12345, 6'd5, 3'b111, 0, 1, 6'b000111, 20'hABCDE, "R8");
      fill(20'h40000, 6'd9, 3'b100, 1, 1, 6'b111000, 20'h77000, "R8");
      fill(20'h56780, 6'd5, 3'b110, 0, 0, 6'b001001, 20'h33330, "R11");
      fill(20'h12345, 6'd5, 3'b111, 0, 1, 6'b111111, 20'h11111, "R10");
      fill(20'h9A000, 6'd6, 3'b111, 0, 1, 6'b111111, 20'h5A5A5, "R3");
      fill(20'hC0000, 6'd5, 3'b101, 0, 1, 6'b111111, 20'h0F000, "R2");
      fill(20'hE0000, 6'd5, 3'b011, 0, 1, 6'b111111, 20'h0E000, "R2");
      // R2/R4: spans and address splice
      look(32'h1234_5ABC, 2'd0, 0, 0, "R4");
      look(32'h1234_6ABC, 2'd0, 0, 0, "R2");
      look(32'h40FF_FFFF, 2'd0, 1, 0, "R4");
      look(32'h5679_1234, 2'd0, 0, 0, "R4");
      look(32'h567C_1234, 2'd0, 0, 0, "R2");
      look(32'hC0AB_CDEF, 2'd2, 0, 0, "R2");
      look(32'hE000_0123, 2'd0, 0, 0, "R2");
      // R3: supervisor entry in any context, others only in their own
      look(32'h4012_3456, 2'd0, 1, 0, "R3");
      look(32'h9A00_0010, 2'd0, 0, 0, "R3");
      // R6: permission index and reserved access code
      look(32'h40FF_FFFF, 2'd0, 0, 0, "R6");
      look(32'h1234_5000, 2'd2, 0, 0, "R6");
      look(32'h1234_5000, 2'd3, 0, 0, "R6");
      look(32'h5678_0000, 2'd0, 1, 0, "R6");
      look(32'h5678_0000, 2'd1, 1, 0, "R6");
      // R7: modified bit
      look(32'h1234_5010, 2'd1, 0, 0, "R7");
      look(32'h1234_5010, 2'd1, 0, 1, "R7");
      look(32'h1234_5010, 2'd1, 0, 1, "R7");
      look(32'h1234_5010, 2'd0, 0, 0, "R7");
      look(32'h5678_0004, 2'd1, 0, 1, "R7");
      look(32'h5678_0004, 2'd0, 0, 0, "R7");
      // R12 again: switch context
      ctx_we_i = 1; ctx_wdata_i = 6'd6; cyc("R12"); ctx_we_i = 0;
      look(32'h9A00_0010, 2'd0, 0, 0, "R12");
      look(32'h1234_5010, 2'd0, 0, 0, "R3");
      // R9: flush with a colliding fill
      flush_i = 1; fill_we_i = 1; fill_vtag_i = 20'h9A000; fill_ctx_i = 6'd6;
      fill_level_i = 3'b111; fill_perm_i = 6'b111111; cyc("R9");
      flush_i = 0; fill_we_i = 0;
      look(32'h9A00_0010, 2'd0, 0, 0, "R9");
      look(32'h40FF_FFFF, 2'd0, 1, 0, "R9");
      // R8: wrap the fill slot
      for (int k = 0; k < N + 3; k++)
         fill(20'h20000 + 20'(k), 6'd6, 3'b111, 0, 1, 6'b000001, 20'h80000 + 20'(k), "R8");
      for (int k = 0; k < N + 3; k++)
         look({12'h200, 8'(k), 12'h345}, 2'd0, 0, 0, "R8");
      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         flush_i = (r == 0);
         fill_we_i = (r > 70);
         ctx_we_i = (r > 5 && r < 9);
         ctx_wdata_i = 6'($urandom_range(0, 2));
         fill_vtag_i = {4'hA, 2'($urandom_range(0, 1)), 6'($urandom_range(0, 3)),
                        2'($urandom_range(0, 1)), 6'($urandom_range(0, 3))};
         fill_ctx_i = 6'($urandom_range(0, 2));
         fill_level_i = 3'($urandom_range(0, 7));
         fill_sup_i = 1'($urandom_range(0, 1));
         fill_io_n_i = 1'($urandom_range(0, 1));
         fill_perm_i = 6'($urandom);
         fill_ppn_i = 20'($urandom);
         lk_req_i = 1'($urandom_range(0, 1));
         lk_acc_i = 2'($urandom_range(0, 3));
         lk_priv_i = 1'($urandom_range(0, 1));
         lk_va_i = {4'hA, 2'($urandom_range(0, 1)), 6'($urandom_range(0, 3)),
                    2'($urandom_range(0, 1)), 6'($urandom_range(0, 3)), 12'($urandom)};
         cyc("R2");
      end
      flush_i = 0; fill_we_i = 0; ctx_we_i = 0; lk_req_i = 0;
      finish_run();
   end
endmodule